// File: doc/BRIEF.md
# Balanced-Ternary Parity Generator and Checker

This block protects a word of balanced-ternary digits with a single parity digit. Each digit is held in binary hardware as a 2-bit code. The generator side adds all data digits together modulo 3 and returns the result as a balanced digit. It is a purely combinational output, so a sender can attach it to the word in the same cycle.

The checker side takes a received word and its received parity digit. It forms a syndrome digit, which is the data sum minus the received parity, reduced modulo 3. The result is captured in output registers on the clock edge that samples a valid strobe. A zero syndrome means no error was seen. A plus or minus syndrome raises the error flag, and its sign shows which way a single corrupted digit was shifted.

A separate flag reports any illegal 2-bit code on the data or parity inputs. Detection of errors in several digits is not guaranteed: roughly one random multi-digit corruption in three cancels out. The block does not correct errors.

Top module: `tparity_top`

## Requirements
- R1: Digit codes are 2'b11 = minus (-1), 2'b00 = zero, 2'b01 = plus (+1). The code 2'b10 is illegal. No output digit (`par_o`, `synd_q`) ever carries 2'b10.
- R2: `par_o` is, combinationally, the sum of the N data digits of `data_i` (digit i at bits [2i+1:2i]) taken modulo 3 and mapped into {-1,0,+1}. For example, two plus digits give minus, two minus digits give plus, and three plus digits give zero.
- R3: `vld_q` is high for exactly the cycle after each clock edge that samples `valid_i` high, and low otherwise.
- R4: On a sampled strobe, `synd_q` becomes (data sum − `par_i`) modulo 3 in balanced form. A word sent with `par_i` equal to its own `par_o` therefore gives zero.
- R5: `err_q` is 1 exactly when the captured syndrome is non-zero.
- R6: If one data digit is shifted by +1 modulo 3 from a correct codeword, the syndrome is plus. If it is shifted by −1, the syndrome is minus.
- R7: If only the parity digit is shifted by +1 modulo 3, the syndrome is minus. If it is shifted by −1, the syndrome is plus.
- R8: An illegal code in any data digit or in `par_i` sets `bad_q` on the strobe. An illegal digit counts as zero in both `par_o` and the syndrome.
- R9: While `valid_i` is low, `synd_q`, `err_q` and `bad_q` keep their values, whatever happens on the data and parity inputs.
- R10: A synchronous active-high `rst` clears `vld_q`, `err_q` and `bad_q` and sets `synd_q` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Strobe: capture a check of `data_i`/`par_i` on this edge |
| data_i | input | 2*N | N data digits, digit i at bits [2i+1:2i] |
| par_i | input | 2 | Received parity digit |
| par_o | output | 2 | Generated parity digit of `data_i` (combinational) |
| vld_q | output | 1 | Registered: a check result was captured last edge |
| synd_q | output | 2 | Registered syndrome digit |
| err_q | output | 1 | Registered: syndrome non-zero |
| bad_q | output | 1 | Registered: an illegal code was seen on the inputs |

## Verification
`par_o` has no register on its path, so it is due in the same cycle as its input. The bench settles it with a short delay after each input change and compares it, over every one of the 3^9 data words, with an integer sum reduced modulo 3. The registered results (`vld_q`, `synd_q`, `err_q`, `bad_q`) are due on the first rising edge that sees `valid_i` high. The bench therefore drives the strobe on a falling edge, drops it on the next falling edge, and reads the results at that same point, half a period after they were captured. Hold behaviour is read two falling edges later with the strobe kept low.

// File: rtl/tparity_pkg.sv
package tparity_pkg;

  // 2-bit digit codes
  localparam logic [1:0] T_NEG  = 2'b11;
  localparam logic [1:0] T_ZERO = 2'b00;
  localparam logic [1:0] T_POS  = 2'b01;
  localparam logic [1:0] T_BAD  = 2'b10;

  function automatic logic trit_legal(input logic [1:0] c);
    return c != T_BAD;
  endfunction

  // residue 0,1,2 standing for 0,+1,-1
  function automatic logic [1:0] trit_res(input logic [1:0] c);
    case (c)
      T_POS:   return 2'd1;
      T_NEG:   return 2'd2;
      default: return 2'd0;   // zero and illegal both count as zero
    endcase
  endfunction

  function automatic logic [1:0] res_trit(input logic [1:0] r);
    case (r)
      2'd1:    return T_POS;
      2'd2:    return T_NEG;
      default: return T_ZERO;
    endcase
  endfunction

  // modulo-3 sum of two digits
  function automatic logic [1:0] trit_sum(input logic [1:0] a, input logic [1:0] b);
    logic [2:0] r;
    r = {1'b0, trit_res(a)} + {1'b0, trit_res(b)};
    if (r >= 3'd3) r = r - 3'd3;
    return res_trit(r[1:0]);
  endfunction

  function automatic logic [1:0] trit_neg(input logic [1:0] a);
    case (a)
      T_POS:   return T_NEG;
      T_NEG:   return T_POS;
      default: return T_ZERO;
    endcase
  endfunction

  // a - b modulo 3
  function automatic logic [1:0] trit_diff(input logic [1:0] a, input logic [1:0] b);
    return trit_sum(a, trit_neg(b));
  endfunction

endpackage

// File: rtl/tparity_fold.sv
module tparity_fold
  import tparity_pkg::*;
#(
  parameter int N = 9
) (
  input  logic [2*N-1:0] digits,
  output logic [1:0]     sum,
  output logic           any_bad
);
  localparam int LAST = N - 1;

  logic [1:0]   stage [N];
  logic [N-1:0] bad_vec;

  assign stage[0] = trit_sum(T_ZERO, digits[1:0]);

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bad
      assign bad_vec[i] = !trit_legal(digits[2*i +: 2]);
    end
    for (i = 1; i < N; i++) begin : g_chain
      assign stage[i] = trit_sum(stage[i-1], digits[2*i +: 2]);
    end
  endgenerate

  assign sum     = stage[LAST];
  assign any_bad = |bad_vec;

  // R1: the sum chain never yields the illegal code
  always_comb begin
    if (!$isunknown(sum)) a_r1_fold_legal: assert (sum != T_BAD);
  end

endmodule

// File: rtl/tparity_synd.sv
module tparity_synd
  import tparity_pkg::*;
(
  input  logic [1:0] dsum,
  input  logic [1:0] par,
  output logic [1:0] synd,
  output logic       nonzero,
  output logic       par_bad
);
  assign synd    = trit_diff(dsum, par);
  assign nonzero = synd != T_ZERO;
  assign par_bad = !trit_legal(par);

  // R1: the syndrome is always a legal digit
  always_comb begin
    if (!$isunknown(synd)) a_r1_synd_legal: assert (synd != T_BAD);
  end

endmodule

// File: rtl/tparity_top.sv
module tparity_top
  import tparity_pkg::*;
#(
  parameter int N = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid_i,
  input  logic [2*N-1:0] data_i,
  input  logic [1:0]     par_i,
  output logic [1:0]     par_o,
  output logic           vld_q,
  output logic [1:0]     synd_q,
  output logic           err_q,
  output logic           bad_q
);
  logic [1:0] data_sum;
  logic       data_bad;
  logic [1:0] synd_w;
  logic       synd_nz;
  logic       par_bad;

  tparity_fold #(.N(N)) u_fold (
    .digits  (data_i),
    .sum     (data_sum),
    .any_bad (data_bad)
  );

  tparity_synd u_synd (
    .dsum    (data_sum),
    .par     (par_i),
    .synd    (synd_w),
    .nonzero (synd_nz),
    .par_bad (par_bad)
  );

  assign par_o = data_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      synd_q <= T_ZERO;
      err_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        synd_q <= synd_w;
        err_q  <= synd_nz;
        bad_q  <= data_bad | par_bad;
      end
    end
  end

  a_r3_vld_follows: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> vld_q);

  a_r3_vld_drops: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !vld_q);

  a_r4_codeword_zero: assert property (@(posedge clk) disable iff (rst)
    (valid_i && par_i == par_o) |=> (synd_q == T_ZERO && !err_q));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(synd_q) && $stable(err_q) && $stable(bad_q)));

  a_r5_err_sign: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (err_q == (synd_q != T_ZERO)));

endmodule

// File: tb/tparity_top_tb.sv
`timescale 1ns/1ps
module tparity_top_tb;
  localparam int N = 9;
  localparam int W = 2 * N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         valid_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [1:0]   par_i = 2'b00;
  logic [1:0]   par_o;
  logic         vld_q;
  logic [1:0]   synd_q;
  logic         err_q;
  logic         bad_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  tparity_top #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .data_i(data_i), .par_i(par_i),
    .par_o(par_o), .vld_q(vld_q), .synd_q(synd_q), .err_q(err_q), .bad_q(bad_q)
  );

  always #2.5 clk = ~clk;

  function automatic logic [1:0] enc(input int v);
    int r;
    r = ((v % 3) + 3) % 3;
    return (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
  endfunction

  function automatic int dec(input logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  function automatic int int_sum(input logic [W-1:0] w);
    int s = 0;
    for (int i = 0; i < N; i++) s += dec(w[2*i +: 2]);
    return s;
  endfunction

  function automatic logic [W-1:0] rand_word();
    logic [W-1:0] w;
    for (int i = 0; i < N; i++) w[2*i +: 2] = enc($urandom_range(0, 2));
    return w;
  endfunction

  task automatic chk2(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // strobe on a falling edge; results are read on the next falling edge
  task automatic apply(input logic [W-1:0] w, input logic [1:0] p);
    @(negedge clk);
    data_i  = w;
    par_i   = p;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [1:0] s, input logic bad);
    chk1({req, " vld"}, vld_q, 1'b1);
    chk2({req, " synd"}, synd_q, s);
    chk1({req, " err"}, err_q, s != 2'b00);
    chk1({req, " bad"}, bad_q, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w;
    logic [W-1:0] w2;
    logic [1:0]   p;
    int           d;
    int           v;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk1("R10 vld", vld_q, 1'b0);
    chk2("R10 synd", synd_q, 2'b00);
    chk1("R10 err", err_q, 1'b0);
    chk1("R10 bad", bad_q, 1'b0);
    rst = 1'b0;

    // R1 R2: exhaustive sweep of the combinational parity
    for (int idx = 0; idx < 19683; idx++) begin
      v = idx;
      for (int i = 0; i < N; i++) begin
        w[2*i +: 2] = enc((v % 3 == 2) ? -1 : v % 3);
        v = v / 3;
      end
      data_i = w;
      #0.1;
      chk2("R2 par_o", par_o, enc(int_sum(w)));
    end
    data_i = '0;
    data_i[1:0] = 2'b01; data_i[3:2] = 2'b01; #0.1;
    chk2("R2 two plus", par_o, 2'b11);
    data_i[5:4] = 2'b01; #0.1;
    chk2("R1 R2 three plus", par_o, 2'b00);

    // R3 R4 R5: correct codewords give zero; vld_q is one cycle wide
    for (int k = 0; k < 30; k++) begin
      w = rand_word();
      apply(w, enc(int_sum(w)));
      expect_out("R4 codeword", 2'b00, 1'b0);
      @(negedge clk);
      chk1("R3 vld one cycle", vld_q, 1'b0);
    end

    // R6: every single data digit error, both directions
    for (int k = 0; k < 12; k++) begin
      w = rand_word();
      p = enc(int_sum(w));
      for (int i = 0; i < N; i++) begin
        for (int s = 0; s < 2; s++) begin
          d = (s == 0) ? 1 : -1;
          w2 = w;
          w2[2*i +: 2] = enc(dec(w[2*i +: 2]) + d);
          apply(w2, p);
          expect_out("R6 digit error", enc(d), 1'b0);
        end
      end
      // R7: parity digit errors
      for (int s = 0; s < 2; s++) begin
        d = (s == 0) ? 1 : -1;
        apply(w, enc(dec(p) + d));
        expect_out("R7 parity error", enc(-d), 1'b0);
      end
    end

    // R4 R5: random multi-digit words and random parity
    for (int k = 0; k < 300; k++) begin
      w = rand_word();
      p = enc($urandom_range(0, 2));
      apply(w, p);
      expect_out("R4 R5 random", enc(int_sum(w) - dec(p)), 1'b0);
    end

    // R8: illegal data digit counts as zero and raises bad_q
    w = rand_word();
    w[7:6] = 2'b10;
    data_i = w; #0.1;
    chk2("R8 par_o illegal digit", par_o, enc(int_sum(w)));
    apply(w, enc(int_sum(w)));
    expect_out("R8 illegal digit", 2'b00, 1'b1);
    // R8: illegal parity counts as zero
    w = rand_word();
    apply(w, 2'b10);
    expect_out("R8 illegal parity", enc(int_sum(w)), 1'b1);
    // legal strobe clears bad_q
    apply(w, enc(int_sum(w)));
    expect_out("R8 clear", 2'b00, 1'b0);

    // R9: hold while valid_i is low
    w = rand_word();
    apply(w, enc(int_sum(w) - 1));
    data_i = rand_word();
    par_i  = 2'b10;
    @(negedge clk);
    @(negedge clk);
    chk1("R9 vld low", vld_q, 1'b0);
    chk2("R9 synd hold", synd_q, 2'b01);
    chk1("R9 err hold", err_q, 1'b1);
    chk1("R9 bad hold", bad_q, 1'b0);

    // R10: reset after activity
    apply(w, 2'b10);
    rst = 1'b1;
    @(negedge clk);
    chk1("R10 vld after", vld_q, 1'b0);
    chk2("R10 synd after", synd_q, 2'b00);
    chk1("R10 err after", err_q, 1'b0);
    chk1("R10 bad after", bad_q, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule